// File: doc/BRIEF.md
# Master Serial Configuration Loader

This block is the receiving side of a serial boot from an external configuration PROM chain. It sits idle until a request line rises; that line is normally the PROM's open-drain ready output, released once the PROM has finished its power-on reset. When the boot-select input is high at that edge, the loader drives its PROM enable and PROM clear strobes low. It then runs a divided serial clock for exactly as many cycles as the bitstream has bits, and samples one data bit per serial clock period.

Received bits are packed most-significant-first into words of a parameterised width. Each word is presented with a one-cycle valid strobe. A final word that is only partly filled is flushed with its bits aligned to the top. After the last bit, the serial clock is parked low. In the same cycle the strobes are released and the done output goes high. The PROM clear strobe being high rewinds the PROM address, so every load starts at the beginning of the stream.

Top module: `serial_boot_loader`

## Requirements
- R1: After reset, the serial clock is 0, the PROM enable (active low) and PROM clear outputs are 1, load done is 0, and the word valid strobe is 0.
- R2: A rising edge of the load request, seen while idle with boot select at 1, drives the PROM enable, the PROM clear and load done to 0 within 3 system clock cycles. The serial clock is still 0 at that point and only rises later, with both strobes already low.
- R3: A request edge that arrives while boot select is 0 is ignored. The strobes stay high and the serial clock produces no edge.
- R4: During a load, each high phase and each low phase of the serial clock after the first lasts exactly HALF_PERIOD system clock cycles. A load contains exactly STREAM_BITS rising edges.
- R5: The data input is sampled in the system clock cycle just before each serial clock rising edge. Bit k of the stream is the value present after the k-th rising edge, counting from 0, so bit 0 is the value present before the first rise.
- R6: Stream bit k lands in word k/WORD_BITS at bit position WORD_BITS-1-(k mod WORD_BITS), so the first bit goes to the MSB. Each word is marked by a valid strobe that lasts exactly one cycle.
- R7: When STREAM_BITS is not a multiple of WORD_BITS, the last word is emitted after the final bit. It holds the remaining bits at the top and zeros in the lower positions.
- R8: The serial clock returns to 0 at the end of the high phase that follows the last bit. In that same cycle the PROM enable and PROM clear go to 1 and load done goes to 1, and all of them hold until the next load.
- R9: A request edge that arrives during a load is ignored. It neither restarts nor extends the load, and it leaves no pending start once load done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_sel_i | input | 1 | 1 enables serial loading from the external PROM |
| load_req_i | input | 1 | Load request; its rising edge starts a load (asynchronous, synchronised inside) |
| ser_din_i | input | 1 | Serial configuration data from the PROM |
| ser_clk_o | output | 1 | Divided serial clock to the PROM |
| prom_en_n_o | output | 1 | PROM enable, active low |
| prom_clr_o | output | 1 | PROM address clear / output enable, low during a load |
| load_done_o | output | 1 | High once a load has completed |
| cfg_word_o | output | WORD_BITS | Packed received word |
| cfg_word_vld_o | output | 1 | One-cycle strobe marking a new word |

## Verification
The bench builds the loader with STREAM_BITS=44, WORD_BITS=8 and HALF_PERIOD=4. The 44-bit stream leaves a 4-bit remainder, so every load exercises the partial-word flush as well as five full words. A half period of 4 cycles at a 100 MHz system clock gives a 12.5 MHz serial clock with 40 ns phases, which lets the phase widths be measured exactly. The short stream keeps each load near 360 cycles, so repeated loads fit easily: random and directed images, a request pulse during a load, and a request with boot select low.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_SETUP = 2'd1,
        LD_SHIFT = 2'd2
    } ld_state_e;

endpackage

// File: rtl/cfgl_rise_detect.sv
module cfgl_rise_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } rd_reg_t;

    rd_reg_t d, q;

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], async_i};
        d.prev = q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise_o = q.sync[SYNC_STAGES-1] & ~q.prev;

    // R9
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/cfgl_clk_gen.sv
module cfgl_clk_gen #(
    parameter int HALF_PERIOD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic ser_clk_o,
    output logic sample_tick_o,
    output logic fall_tick_o
);

    localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sclk;
    } cg_reg_t;

    cg_reg_t d, q;
    logic    at_last;

    assign at_last = (q.cnt == CNT_LAST);

    always_comb begin
        d = q;
        if (!run_i) begin
            d.cnt  = '0;
            d.sclk = 1'b0;
        end else if (at_last) begin
            d.cnt  = '0;
            d.sclk = ~q.sclk;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ser_clk_o     = q.sclk;
    assign sample_tick_o = run_i & ~q.sclk & at_last;
    assign fall_tick_o   = run_i &  q.sclk & at_last;

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !at_last) |=> $stable(q.sclk));

    // R3
    parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !ser_clk_o);

endmodule

// File: rtl/cfgl_word_packer.sv
module cfgl_word_packer #(
    parameter int WORD_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 bit_vld_i,
    input  logic                 bit_i,
    input  logic                 bit_last_i,
    output logic [WORD_BITS-1:0] word_o,
    output logic                 word_vld_o
);

    localparam int CW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
    localparam logic [CW-1:0] POS_TOP = CW'(WORD_BITS - 1);

    typedef struct packed {
        logic [WORD_BITS-1:0] sh;
        logic [CW-1:0]        cnt;
        logic [WORD_BITS-1:0] word;
        logic                 vld;
    } wp_reg_t;

    wp_reg_t              d, q;
    logic [WORD_BITS-1:0] nxt;

    assign nxt = {q.sh[WORD_BITS-2:0], bit_i};

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (clear_i) begin
            d.cnt = '0;
        end else if (bit_vld_i) begin
            if (q.cnt == POS_TOP) begin
                d.word = nxt;
                d.vld  = 1'b1;
                d.cnt  = '0;
            end else if (bit_last_i) begin
                d.word = nxt << (POS_TOP - q.cnt);
                d.vld  = 1'b1;
                d.cnt  = '0;
            end else begin
                d.sh  = nxt;
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_o     = q.word;
    assign word_vld_o = q.vld;

    // R6
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |=> !word_vld_o);

    // R6
    vld_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> $past(bit_vld_i));

endmodule

// File: rtl/serial_boot_loader.sv
module serial_boot_loader
    import cfg_loader_pkg::*;
#(
    parameter int STREAM_BITS = 64,
    parameter int WORD_BITS   = 8,
    parameter int HALF_PERIOD = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 boot_sel_i,
    input  logic                 load_req_i,
    input  logic                 ser_din_i,
    output logic                 ser_clk_o,
    output logic                 prom_en_n_o,
    output logic                 prom_clr_o,
    output logic                 load_done_o,
    output logic [WORD_BITS-1:0] cfg_word_o,
    output logic                 cfg_word_vld_o
);

    localparam int BCW = $clog2(STREAM_BITS + 1);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(STREAM_BITS - 1);

    typedef struct packed {
        ld_state_e      state;
        logic [BCW-1:0] bit_cnt;
        logic           last;
        logic           done;
        logic           drive_low;
    } ld_reg_t;

    ld_reg_t d, q;
    logic    req_rise;
    logic    sample_tick;
    logic    fall_tick;
    logic    start;
    logic    running;

    cfgl_rise_detect #(.SYNC_STAGES(SYNC_STAGES)) u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (load_req_i),
        .rise_o  (req_rise)
    );

    assign running = (q.state == LD_SHIFT);
    assign start   = (q.state == LD_IDLE) && req_rise && boot_sel_i;

    cfgl_clk_gen #(.HALF_PERIOD(HALF_PERIOD)) u_clk (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_i         (running),
        .ser_clk_o     (ser_clk_o),
        .sample_tick_o (sample_tick),
        .fall_tick_o   (fall_tick)
    );

    cfgl_word_packer #(.WORD_BITS(WORD_BITS)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start),
        .bit_vld_i  (sample_tick),
        .bit_i      (ser_din_i),
        .bit_last_i (q.bit_cnt == LAST_BIT),
        .word_o     (cfg_word_o),
        .word_vld_o (cfg_word_vld_o)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            LD_IDLE: begin
                if (start) begin
                    d.state     = LD_SETUP;
                    d.drive_low = 1'b1;
                    d.done      = 1'b0;
                    d.bit_cnt   = '0;
                    d.last      = 1'b0;
                end
            end
            LD_SETUP: begin
                d.state = LD_SHIFT;
            end
            LD_SHIFT: begin
                if (sample_tick) begin
                    d.bit_cnt = q.bit_cnt + 1'b1;
                    if (q.bit_cnt == LAST_BIT) d.last = 1'b1;
                end
                if (fall_tick && q.last) begin
                    d.state     = LD_IDLE;
                    d.drive_low = 1'b0;
                    d.done      = 1'b1;
                end
            end
            default: d.state = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign prom_en_n_o = ~q.drive_low;
    assign prom_clr_o  = ~q.drive_low;
    assign load_done_o = q.done;

    // R2
    strobe_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk_o) |-> (!prom_en_n_o && !prom_clr_o));

    // R8
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_done_o |-> (prom_en_n_o && prom_clr_o && !ser_clk_o));

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == LD_SHIFT) |=> (q.state != LD_SETUP));

    // R4
    bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.bit_cnt <= BCW'(STREAM_BITS));

endmodule

// File: tb/serial_boot_loader_test.sv
module serial_boot_loader_test;

    localparam int STREAM_BITS = 44;
    localparam int WORD_BITS   = 8;
    localparam int HALF_PERIOD = 4;
    localparam int NWORDS      = (STREAM_BITS + WORD_BITS - 1) / WORD_BITS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boot_sel = 1'b0;
    logic load_req = 1'b0;
    logic ser_din;
    logic ser_clk, prom_en_n, prom_clr, load_done, word_vld;
    logic [WORD_BITS-1:0] word;

    int checks = 0;
    int fails  = 0;

    logic [STREAM_BITS-1:0] image = '0;
    int   addr = 0;
    logic clk_prev = 1'b0;
    int   wid = 0;
    bit   fall_in_load = 1'b0;
    int   rises = 0;
    int   phase_err = 0;
    logic [WORD_BITS-1:0] cap [0:63];
    int   cap_n = 0;

    always #5 clk = ~clk;

    serial_boot_loader #(
        .STREAM_BITS (STREAM_BITS),
        .WORD_BITS   (WORD_BITS),
        .HALF_PERIOD (HALF_PERIOD)
    ) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .boot_sel_i     (boot_sel),
        .load_req_i     (load_req),
        .ser_din_i      (ser_din),
        .ser_clk_o      (ser_clk),
        .prom_en_n_o    (prom_en_n),
        .prom_clr_o     (prom_clr),
        .load_done_o    (load_done),
        .cfg_word_o     (word),
        .cfg_word_vld_o (word_vld)
    );

    assign ser_din = (addr < STREAM_BITS) ? image[addr] : 1'b0;

    // PROM model and output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (prom_clr)
            addr = 0;
        else if (ser_clk && !clk_prev && !prom_en_n)
            addr = addr + 1;
        if (ser_clk != clk_prev) begin
            if (clk_prev) begin
                if (wid != HALF_PERIOD) phase_err++;
                fall_in_load = !load_done;
            end else begin
                rises++;
                if (fall_in_load && wid != HALF_PERIOD) phase_err++;
            end
            wid = 1;
        end else begin
            wid++;
        end
        clk_prev = ser_clk;
        if (word_vld) begin
            if (cap_n < 64) cap[cap_n] = word;
            cap_n++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [WORD_BITS-1:0] exp_word(input int j);
        logic [WORD_BITS-1:0] w;
        for (int b = 0; b < WORD_BITS; b++) begin
            int pos;
            pos = j * WORD_BITS + b;
            w[WORD_BITS-1-b] = (pos < STREAM_BITS) ? image[pos] : 1'b0;
        end
        return w;
    endfunction

    task automatic do_load(input bit glitch);
        int r0, p0, w0, t, low_seen;
        logic prev;
        r0 = rises; p0 = phase_err; w0 = cap_n;
        @(negedge clk) load_req = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2 start strobes", {28'd0, prom_en_n, prom_clr, load_done, ser_clk}, 32'h0);
        t = 0; prev = 1'b0;
        while (!load_done && t < 2000) begin
            prev = ser_clk;
            @(negedge clk);
            t++;
            if (glitch && t == 100) load_req = 1'b0;
            if (glitch && t == 104) load_req = 1'b1;
        end
        chk("R8 load completes", {31'd0, t < 2000}, 32'd1);
        chk("R8 release timing", {28'd0, prev, ser_clk, prom_en_n, prom_clr}, 32'hB);
        chk("R4 rise count", rises - r0, STREAM_BITS);
        chk("R4 phase widths", phase_err - p0, 0);
        chk("R6 word count", cap_n - w0, NWORDS);
        for (int j = 0; j < NWORDS; j++) begin
            if (w0 + j < 64) begin
                if (j == NWORDS - 1 && (STREAM_BITS % WORD_BITS) != 0)
                    chk("R7 partial word", {24'd0, cap[w0 + j]}, {24'd0, exp_word(j)});
                else
                    chk("R5 R6 word", {24'd0, cap[w0 + j]}, {24'd0, exp_word(j)});
            end
        end
        low_seen = 0;
        r0 = rises;
        repeat (30) begin
            @(negedge clk);
            if (!prom_en_n || !load_done) low_seen++;
        end
        chk(glitch ? "R9 no pending start" : "R8 done holds", low_seen, 0);
        chk("R9 no extra clock", rises - r0, 0);
        @(negedge clk) load_req = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int low_cnt, r0;
        void'($urandom(32'd7321));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 reset state", {27'd0, ser_clk, prom_en_n, prom_clr, load_done, word_vld}, 32'b01100);

        // R3: boot select low
        r0 = rises; low_cnt = 0;
        @(negedge clk) load_req = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (!prom_en_n || !prom_clr) low_cnt++;
        end
        chk("R3 strobes held", low_cnt, 0);
        chk("R3 no clock", rises - r0, 0);
        @(negedge clk) load_req = 1'b0;
        boot_sel = 1'b1;
        repeat (5) @(negedge clk);

        // directed: alternating pattern
        for (int i = 0; i < STREAM_BITS; i++) image[i] = i[0];
        do_load(1'b0);
        // directed: all ones
        image = '1;
        do_load(1'b0);
        // random images, one with a request pulse mid-load
        for (int n = 0; n < 3; n++) begin
            for (int i = 0; i < STREAM_BITS; i++) image[i] = 1'($urandom_range(0, 1));
            do_load(n == 1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule